// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block steers a programmable device from power-on into user mode. After reset, or whenever the program request input is raised, it enters a memory-clearing phase. During that phase it pulls the open-drain init line low, which appears here as a drive-low output plus a sensed input. Once its own clearing time has elapsed, it lets go of the line. It then waits until the sensed line actually reads high. Another device may hold the line low to postpone configuration. After that it waits for a data-load-complete strobe from the loader.

When the load completes, a phase counter runs through start-up phases 0 to 7 on the start-up clock, and the global controls change at parameterised phases. With the defaults, done rises at phase 4, the global three-state hold is released at phase 5, and the global set/reset hold and the global write-enable block are both released at phase 6. Two mode inputs can stall this counter. In sync-to-done mode, the steps into the three-state and write-enable phases need an external all-devices-done input to be high. In lock-wait mode, the counter halts at a chosen phase until a clock-manager lock input is high. After phase 7 the block stays in user mode until the next program request or reset.

Program request and the sensed init line pass through two-flop synchronisers before use. The other inputs are taken to be synchronous to the start-up clock.

Top module: `cfg_startup_seq`

## Requirements
- R1: While reset is asserted, the outputs are: init driven low, done low, three-state hold high, set/reset hold high, write enable low. After reset release, the init drive ends on the CLEAR_CYCLES-th rising edge.
- R2: A high program request restarts the sequence from clearing with the same output values as under reset. This takes effect three edges after the request is first sampled, and it wins over any start-up phase step due on that edge.
- R3: After program request falls, init stays driven low until the (CLEAR_CYCLES+2)-th rising edge. Two of those edges belong to the synchroniser.
- R4: While the sensed init line stays low after clearing, the block does not begin loading, and a data-load strobe has no effect: done stays low.
- R5: The set/reset hold stays high and write enable stays low for as long as done is low.
- R6: With both modes off, done rises on the 5th rising edge, counting the edge that samples the load strobe as the 1st (phase 4).
- R7: With both modes off, the three-state hold falls one edge after done rises. Write enable rises, and the set/reset hold falls, one edge after that.
- R8: In sync-to-done mode, each step into the three-state phase (5) and into the write-enable phase (6) happens only on an edge where all-done is high.
- R9: In lock-wait mode, the phase counter stays at LOCK_PHASE (default 3) until an edge samples lock high.
- R10: After phase 7 the block holds done high, three-state hold low, set/reset hold low and write enable high. Changes on the load strobe, all-done or lock do not alter these outputs.
- R11: With a mode input low, the matching condition input (all-done or lock) has no effect on the release timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Start-up clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| progReq | input | 1 | Program request, asynchronous, active high |
| initSense | input | 1 | Sensed level of the open-drain init line |
| loadDone | input | 1 | Configuration data load complete strobe |
| allDone | input | 1 | External all-devices-done indication |
| lockIn | input | 1 | Clock-manager lock indication |
| syncToDone | input | 1 | Mode: gate the release steps on allDone |
| lockHold | input | 1 | Mode: halt at LOCK_PHASE until lockIn |
| initDriveLow | output | 1 | Pull the init line low |
| doneOut | output | 1 | Configuration complete |
| gtsHold | output | 1 | Global three-state hold, active high |
| gsrHold | output | 1 | Global set/reset hold, active high |
| gweEn | output | 1 | Global write enable |

## Verification
A program request can land on the very edge where the phase counter would step into the done phase. The restart and the release then compete in one cycle. The bench provokes this by raising program request two edges after the load strobe is sampled, so that the synchronised request reaches the control on the 5th edge. The bench judges the outcome at the ports: after the 4th edge done must still be low and init released, and after the 5th edge init must be driven low with done low. A sweep over both mode inputs, lock arrival times and all-done arrival times also checks the release edges against arithmetic maximum formulas.

// File: rtl/cfg_startup_pkg.sv
package cfg_startup_pkg;

  typedef enum logic [2:0] {
    ST_CLEAR    = 3'd0,
    ST_INITWAIT = 3'd1,
    ST_LOAD     = 3'd2,
    ST_STARTUP  = 3'd3,
    ST_USER     = 3'd4
  } seqState_t;

  typedef struct packed {
    logic clearRst;
    logic phaseRst;
    logic phaseAdv;
  } dpStrobe_t;

endpackage

// File: rtl/cfg_startup_sync.sv
module cfg_startup_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= '0;
    else       stage <= {stage[STAGES-2:0], din};
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/cfg_startup_dp.sv
module cfg_startup_dp
  import cfg_startup_pkg::*;
#(
  parameter int CLEAR_CYCLES = 8,
  parameter int PHASE_COUNT  = 8,
  parameter int PHASE_W      = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  output logic               clearLast,
  output logic [PHASE_W-1:0] phase,
  output logic               phaseLast
);

  localparam int CNT_W = $clog2(CLEAR_CYCLES + 1);
  localparam logic [CNT_W-1:0]   CLR_END = CNT_W'(CLEAR_CYCLES - 1);
  localparam logic [PHASE_W-1:0] PH_END  = PHASE_W'(PHASE_COUNT - 1);

  logic [CNT_W-1:0] clearCnt;

  assign clearLast = (clearCnt == CLR_END);
  assign phaseLast = (phase == PH_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               clearCnt <= '0;
    else if (strobe.clearRst) clearCnt <= '0;
    else if (!clearLast)     clearCnt <= clearCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phase <= '0;
    else if (strobe.phaseRst) phase <= '0;
    else if (strobe.phaseAdv) phase <= phase + 1'b1;
  end

  // R3: clearing counter never runs past its end value
  a_r3_clear_bound: assert property (@(posedge clk) disable iff (!rstN)
    clearCnt <= CLR_END);

  // R9: without an advance strobe the phase does not move
  a_r9_phase_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.phaseAdv && !strobe.phaseRst) |=> $stable(phase));

endmodule

// File: rtl/cfg_startup_ctrl.sv
module cfg_startup_ctrl
  import cfg_startup_pkg::*;
#(
  parameter int PHASE_W     = 3,
  parameter int DONE_PHASE  = 4,
  parameter int GTS_PHASE   = 5,
  parameter int GWE_PHASE   = 6,
  parameter int GSR_PHASE   = 6,
  parameter int LOCK_PHASE  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               progS,
  input  logic               initS,
  input  logic               loadDone,
  input  logic               allDone,
  input  logic               lockIn,
  input  logic               syncToDone,
  input  logic               lockHold,
  input  logic               clearLast,
  input  logic [PHASE_W-1:0] phase,
  input  logic               phaseLast,
  output dpStrobe_t          strobe,
  output logic               initDriveLow,
  output logic               doneOut,
  output logic               gtsHold,
  output logic               gsrHold,
  output logic               gweEn
);

  localparam logic [PHASE_W-1:0] DONE_P = PHASE_W'(DONE_PHASE);
  localparam logic [PHASE_W-1:0] GTS_P  = PHASE_W'(GTS_PHASE);
  localparam logic [PHASE_W-1:0] GWE_P  = PHASE_W'(GWE_PHASE);
  localparam logic [PHASE_W-1:0] GSR_P  = PHASE_W'(GSR_PHASE);
  localparam logic [PHASE_W-1:0] LOCK_P = PHASE_W'(LOCK_PHASE);
  localparam logic [PHASE_W:0]   GTS_N  = (PHASE_W+1)'(GTS_PHASE);
  localparam logic [PHASE_W:0]   GWE_N  = (PHASE_W+1)'(GWE_PHASE);

  seqState_t state, stateNext;
  logic [PHASE_W:0] nextPh;
  logic lockStall, syncStall, inStartup, inUser;

  assign nextPh    = {1'b0, phase} + (PHASE_W+1)'(1);
  assign lockStall = lockHold && (phase == LOCK_P) && !lockIn;
  assign syncStall = syncToDone && !allDone && ((nextPh == GTS_N) || (nextPh == GWE_N));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CLEAR;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (progS) begin
      stateNext       = ST_CLEAR;
      strobe.clearRst = 1'b1;
      strobe.phaseRst = 1'b1;
    end else begin
      unique case (state)
        ST_CLEAR: begin
          strobe.phaseRst = 1'b1;
          if (clearLast) stateNext = ST_INITWAIT;
        end
        ST_INITWAIT: begin
          strobe.clearRst = 1'b1;
          strobe.phaseRst = 1'b1;
          if (initS) stateNext = ST_LOAD;
        end
        ST_LOAD: begin
          strobe.clearRst = 1'b1;
          strobe.phaseRst = 1'b1;
          if (loadDone) stateNext = ST_STARTUP;
        end
        ST_STARTUP: begin
          strobe.clearRst = 1'b1;
          if (!lockStall && !syncStall) begin
            if (phaseLast) stateNext = ST_USER;
            else           strobe.phaseAdv = 1'b1;
          end
        end
        ST_USER: begin
          strobe.clearRst = 1'b1;
        end
        default: stateNext = ST_CLEAR;
      endcase
    end
  end

  assign inStartup    = (state == ST_STARTUP);
  assign inUser       = (state == ST_USER);
  assign initDriveLow = (state == ST_CLEAR);
  assign doneOut      = inUser || (inStartup && phase >= DONE_P);
  assign gtsHold      = !(inUser || (inStartup && phase >= GTS_P));
  assign gweEn        = inUser || (inStartup && phase >= GWE_P);
  assign gsrHold      = !(inUser || (inStartup && phase >= GSR_P));

  // R2: a synchronised program request restores configuration outputs next cycle
  a_r2_prog_restart: assert property (@(posedge clk) disable iff (!rstN)
    progS |=> (initDriveLow && !doneOut && gtsHold && gsrHold && !gweEn));

  // R4: no progress towards done while the sensed init line is low
  a_r4_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INITWAIT && !initS) |=> !doneOut);

  // R5: user state stays held until done
  a_r5_gsr_until_done: assert property (@(posedge clk) disable iff (!rstN)
    !doneOut |-> (gsrHold && !gweEn));

  // R7: write enable only opens after outputs were released
  a_r7_gwe_after_gts: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gweEn) |-> $past(!gtsHold));

  // R8: three-state hold kept while waiting for all-done
  a_r8_sync_stall: assert property (@(posedge clk) disable iff (!rstN)
    (inStartup && syncToDone && !allDone && gtsHold && !progS) |=> gtsHold);

  // R9: phase counter parked at the lock phase until lock
  a_r9_lock_stall: assert property (@(posedge clk) disable iff (!rstN)
    (inStartup && lockHold && !lockIn && phase == LOCK_P && !progS)
      |=> (state == ST_STARTUP && phase == LOCK_P));

  // R10: user mode is kept until a program request
  a_r10_user_stays: assert property (@(posedge clk) disable iff (!rstN)
    (inUser && !progS) |=> (state == ST_USER));

endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
  import cfg_startup_pkg::*;
#(
  parameter int CLEAR_CYCLES = 8,
  parameter int PHASE_COUNT  = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int DONE_PHASE   = 4,
  parameter int GTS_PHASE    = 5,
  parameter int GWE_PHASE    = 6,
  parameter int GSR_PHASE    = 6,
  parameter int LOCK_PHASE   = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic progReq,
  input  logic initSense,
  input  logic loadDone,
  input  logic allDone,
  input  logic lockIn,
  input  logic syncToDone,
  input  logic lockHold,
  output logic initDriveLow,
  output logic doneOut,
  output logic gtsHold,
  output logic gsrHold,
  output logic gweEn
);

  localparam int PHASE_W = $clog2(PHASE_COUNT);

  logic [1:0]         syncOut;
  dpStrobe_t          strobe;
  logic               clearLast, phaseLast;
  logic [PHASE_W-1:0] phase;

  cfg_startup_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({progReq, initSense}),
    .dout(syncOut)
  );

  cfg_startup_dp #(
    .CLEAR_CYCLES(CLEAR_CYCLES),
    .PHASE_COUNT (PHASE_COUNT),
    .PHASE_W     (PHASE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .clearLast(clearLast),
    .phase    (phase),
    .phaseLast(phaseLast)
  );

  cfg_startup_ctrl #(
    .PHASE_W   (PHASE_W),
    .DONE_PHASE(DONE_PHASE),
    .GTS_PHASE (GTS_PHASE),
    .GWE_PHASE (GWE_PHASE),
    .GSR_PHASE (GSR_PHASE),
    .LOCK_PHASE(LOCK_PHASE)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .progS       (syncOut[1]),
    .initS       (syncOut[0]),
    .loadDone    (loadDone),
    .allDone     (allDone),
    .lockIn      (lockIn),
    .syncToDone  (syncToDone),
    .lockHold    (lockHold),
    .clearLast   (clearLast),
    .phase       (phase),
    .phaseLast   (phaseLast),
    .strobe      (strobe),
    .initDriveLow(initDriveLow),
    .doneOut     (doneOut),
    .gtsHold     (gtsHold),
    .gsrHold     (gsrHold),
    .gweEn       (gweEn)
  );

endmodule

// File: tb/cfg_startup_seq_tb.sv
`timescale 1ns/1ps
module cfg_startup_seq_tb;

  localparam int CLR = 6;
  localparam logic [4:0] CFG_VEC  = 5'b10110; // {init,done,gts,gsr,gwe}
  localparam logic [4:0] USER_VEC = 5'b01001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progReq = 1'b0, loadDone = 1'b0, allDone = 1'b0, lockIn = 1'b0;
  logic syncToDone = 1'b0, lockHold = 1'b0, extHold = 1'b0;
  logic initSense;
  logic initDriveLow, doneOut, gtsHold, gsrHold, gweEn;
  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  assign initSense = !initDriveLow && !extHold;

  cfg_startup_seq #(.CLEAR_CYCLES(CLR)) u_dut (
    .clk(clk), .rstN(rstN), .progReq(progReq), .initSense(initSense),
    .loadDone(loadDone), .allDone(allDone), .lockIn(lockIn),
    .syncToDone(syncToDone), .lockHold(lockHold),
    .initDriveLow(initDriveLow), .doneOut(doneOut), .gtsHold(gtsHold),
    .gsrHold(gsrHold), .gweEn(gweEn)
  );

  function automatic logic [4:0] outs();
    return {initDriveLow, doneOut, gtsHold, gsrHold, gweEn};
  endfunction

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // count edges with init still driven low, then let the init sync settle
  task automatic waitClear(input int expHigh, input string req);
    int n = 0;
    for (int i = 0; i < 200; i++) begin
      step();
      if (!initDriveLow) break;
      n++;
    end
    check(n == expHigh, req, n, expHigh);
    repeat (4) step();
  endtask

  task automatic restart();
    progReq = 1'b1;
    repeat (3) step();
    check(outs() == CFG_VEC, "R2 restart outputs", outs(), CFG_VEC);
    step();
    progReq = 1'b0;
    waitClear(CLR + 1, "R3 clear length after program request");
  endtask

  task automatic runStartup(input bit lh, input bit sd, input int nLock, input int mAll);
    int expDone, expGts, expGwe;
    int fDone = 0, fGts = 0, fGwe = 0, fGsr = 0;
    lockHold   = lh;
    syncToDone = sd;
    expDone = lh ? maxi(5, nLock + 1) : 5;
    expGts  = sd ? maxi(expDone + 1, mAll + 1) : expDone + 1;
    expGwe  = expGts + 1;
    loadDone = 1'b1;
    lockIn   = (nLock == 0);
    allDone  = (mAll == 0);
    for (int k = 1; k <= 20; k++) begin
      step();
      loadDone = 1'b0;
      if (fDone == 0 && doneOut)  fDone = k;
      if (fGts == 0 && !gtsHold)  fGts = k;
      if (fGwe == 0 && gweEn)     fGwe = k;
      if (fGsr == 0 && !gsrHold)  fGsr = k;
      if (k == nLock) lockIn = 1'b1;
      if (k == mAll)  allDone = 1'b1;
    end
    check(fDone == expDone, lh ? "R9 done edge with lock wait" : "R6/R11 done edge", fDone, expDone);
    check(fGts == expGts, sd ? "R8 three-state release edge" : "R7/R11 three-state release edge", fGts, expGts);
    check(fGwe == expGwe, "R7 write enable edge", fGwe, expGwe);
    check(fGsr == expGwe, "R5 set/reset release edge", fGsr, expGwe);
    check(outs() == USER_VEC, "R10 user mode outputs", outs(), USER_VEC);
    allDone = 1'b0; lockIn = 1'b0; loadDone = 1'b1;
    step();
    loadDone = 1'b0;
    repeat (3) step();
    check(outs() == USER_VEC, "R10 user mode ignores inputs", outs(), USER_VEC);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : main
    int bad;
    repeat (3) @(negedge clk);
    check(outs() == CFG_VEC, "R1 reset outputs", outs(), CFG_VEC);
    rstN = 1'b1;
    waitClear(CLR - 1, "R1 clear length after reset");

    // sweep modes, lock arrival and all-done arrival
    for (int lh = 0; lh < 2; lh++)
      for (int sd = 0; sd < 2; sd++)
        for (int n = 0; n < 7; n++)
          for (int m = 0; m < 10; m++) begin
            runStartup(lh[0], sd[0], n, m);
            restart();
          end

    // R4: external hold of the init line postpones loading
    lockHold = 1'b0; syncToDone = 1'b0;
    progReq = 1'b1;
    repeat (4) step();
    extHold = 1'b1;
    progReq = 1'b0;
    repeat (CLR + 6) step();
    check(initDriveLow == 1'b0, "R4 init released by block", initDriveLow, 0);
    loadDone = 1'b1;
    step();
    loadDone = 1'b0;
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      step();
      if (doneOut) bad++;
    end
    check(bad == 0, "R4 load ignored while init held low", bad, 0);
    extHold = 1'b0;
    repeat (4) step();
    runStartup(1'b0, 1'b0, 0, 0);

    // R2: program request meets the done phase step on the same edge
    restart();
    loadDone = 1'b1;
    step();
    loadDone = 1'b0;
    step();
    progReq = 1'b1;
    step();
    step();
    check(outs() == 5'b00110, "R2 before collision edge", outs(), 5'b00110);
    step();
    check(outs() == CFG_VEC, "R2 restart wins over done step", outs(), CFG_VEC);
    step();
    progReq = 1'b0;
    waitClear(CLR + 1, "R3 clear length after collision");
    runStartup(1'b1, 1'b1, 2, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule